// File: doc/BRIEF.md
# FIFO Drain Read Port

This block lets a DMA read master empty a buffer over a simple memory-mapped read interface. A producer pushes words into an internal single-clock FIFO. The master issues reads with an active-low strobe. The block ignores the address, so each accepted read returns the oldest word still held.

A two-state gate controls when the master may read. In state `GATE_FILL` the wait-request output is held high. Transition `OPEN_ON_FULL` moves the gate to `GATE_DRAIN` on the clock edge where the FIFO holds `DEPTH` words. In `GATE_DRAIN` the master is served on every cycle it strobes. Transition `CLOSE_ON_EMPTY` moves the gate back to `GATE_FILL` on the edge where the FIFO is seen empty. With the DMA length set to `DEPTH`, each open period matches one DMA transfer.

Each accepted read produces one registered response cycle, in which the data and a one-cycle valid pulse appear together. Everything runs on one clock, and the strobe is used only as a synchronous enable.

Top module: `dma_drain_slave`

## Requirements
- R1: While reset is applied and on the first cycle after it, wait_req is 1, rd_valid is 0, overflow is 0, and the FIFO holds no words.
- R2: wait_req stays 1 until the FIFO holds DEPTH words. It falls to 0 in the cycle after the edge on which the FIFO was full.
- R3: Once wait_req has fallen, the gate stays open until the FIFO becomes empty. It then stays closed (wait_req 1) until the FIFO is full again, even if words are written in between.
- R4: wait_req is 1 in every cycle in which the FIFO holds no words.
- R5: A read is accepted in every cycle in which rd_n is 0 and wait_req is 0. This includes runs of back-to-back cycles, and each accepted read removes one word.
- R6: rd_valid is 1 in the cycle right after each accepted read, for exactly that one cycle. It is 0 in every other cycle.
- R7: The rd_data shown with rd_valid follows the producer's write order. rd_addr has no effect on which word is returned.
- R8: A write made while the FIFO holds DEPTH words is dropped and sets overflow. overflow stays 1 until reset.
- R9: With no writes during an open period and rd_n held at 0, exactly DEPTH reads are served before wait_req returns to 1.
- R10: A write and an accepted read in the same cycle, with the FIFO neither full nor empty, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the producer, the FIFO and the master |
| rst | input | 1 | Synchronous reset, active high |
| prod_wr_en | input | 1 | Producer write enable |
| prod_wr_data | input | WIDTH | Producer write word |
| rd_n | input | 1 | Active-low read strobe from the master |
| rd_addr | input | ADDR_W | Read address; has no effect |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | One-cycle response pulse for each accepted read |
| wait_req | output | 1 | Holds off the master while the gate is closed or the FIFO is empty |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
wait_req comes from combinational logic on the gate state and the FIFO count, so the bench checks it in the same cycle, after it drives the inputs at the falling edge. rd_valid, rd_data, overflow and any gate change are due one rising edge after the stimulus that causes them. The bench keeps a cycle-accurate reference queue and gate state, advances them on each rising edge, and samples the registered outputs just after that edge. A directed drain counts the valid pulses seen while the gate is open and compares the total with DEPTH.

// File: rtl/dds_pkg.sv
package dds_pkg;
    typedef enum logic [0:0] {
        GATE_FILL  = 1'b0,
        GATE_DRAIN = 1'b1
    } gate_state_t;
endpackage

// File: rtl/dds_fifo.sv
module dds_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic             drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] fill;
    logic             do_push, do_pop;

    assign full    = (fill == FULL_CNT);
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = store[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/dds_gate_fsm.sv
module dds_gate_fsm
    import dds_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_full,
    input  logic        fifo_empty,
    output gate_state_t state,
    output logic        hold_off
);
    gate_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= GATE_FILL;
        else     state <= nxt;
    end

    always_comb begin
        nxt      = state;
        hold_off = 1'b1;
        unique case (state)
            GATE_FILL: begin
                hold_off = 1'b1;
                if (fifo_full) nxt = GATE_DRAIN;       // OPEN_ON_FULL
            end
            GATE_DRAIN: begin
                hold_off = fifo_empty;                  // never pop an empty FIFO
                if (fifo_empty) nxt = GATE_FILL;        // CLOSE_ON_EMPTY
            end
            default: begin
                nxt      = GATE_FILL;
                hold_off = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dds_resp_reg.sv
module dds_resp_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             taken,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] data_q,
    output logic             valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= taken;
            if (taken) data_q <= word;
        end
    end
endmodule

// File: rtl/dma_drain_slave.sv
module dma_drain_slave
    import dds_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_wr_en,
    input  logic [WIDTH-1:0]  prod_wr_data,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic              wait_req,
    output logic              overflow
);
    logic             fifo_full, fifo_empty, fifo_drop, accept, addr_fold;
    logic [WIDTH-1:0] fifo_head;
    gate_state_t      gate;

    // The address is folded away: every read takes the FIFO head.
    assign addr_fold = (^rd_addr) | 1'b1;
    assign accept    = !rd_n && !wait_req && addr_fold;

    dds_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(prod_wr_en), .push_data(prod_wr_data),
        .pop(accept), .head(fifo_head),
        .full(fifo_full), .empty(fifo_empty), .drop(fifo_drop)
    );

    dds_gate_fsm u_gate (
        .clk(clk), .rst(rst),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .state(gate), .hold_off(wait_req)
    );

    dds_resp_reg #(.WIDTH(WIDTH)) u_resp (
        .clk(clk), .rst(rst),
        .taken(accept), .word(fifo_head),
        .data_q(rd_data), .valid_q(rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)            overflow <= 1'b0;
        else if (fifo_drop) overflow <= 1'b1;
    end
endmodule

// File: rtl/dds_checker.sv
module dds_checker (
    input logic clk,
    input logic rst,
    input logic rd_n,
    input logic wait_req,
    input logic rd_valid,
    input logic overflow,
    input logic fifo_full,
    input logic fifo_empty
);
    // R4
    empty_holds_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> wait_req);

    // R2
    open_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_req) |-> $past(fifo_full));

    // R6
    valid_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wait_req) |=> rd_valid);

    // R6
    valid_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!(!rd_n && !wait_req)) |=> !rd_valid);

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R3
    stays_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!wait_req && !fifo_empty) |=> (!wait_req || fifo_empty));
endmodule

bind dma_drain_slave dds_checker u_chk (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wait_req(wait_req),
    .rd_valid(rd_valid), .overflow(overflow),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/dma_drain_slave_test.sv
module dma_drain_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int D  = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          we;
    logic [W-1:0]  wd;
    logic          rn;
    logic [AW-1:0] ad;
    logic [W-1:0]  rd_data;
    logic          rd_valid, wait_req, overflow;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [W-1:0] mq[$];
    bit           m_open;
    bit           m_ovf;
    string        data_tag = "R7";
    int           valid_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_drain_slave #(.WIDTH(W), .DEPTH(D), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .prod_wr_en(we), .prod_wr_data(wd),
        .rd_n(rn), .rd_addr(ad), .rd_data(rd_data), .rd_valid(rd_valid),
        .wait_req(wait_req), .overflow(overflow)
    );

    function automatic bit exp_wait();
        return !m_open || (mq.size() == 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [W-1:0] d, input logic r, input logic [AW-1:0] a);
        bit          acc, ew;
        logic [W-1:0] exp_d;
        int          sz;
        @(negedge clk);
        we = w; wd = d; rn = r; ad = a;
        #1;
        ew = exp_wait();
        chk(wait_req == ew, (mq.size() == 0) ? "R4" : (m_open ? "R3" : "R2"), W'(wait_req), W'(ew));
        acc = !r && !ew;
        sz  = mq.size();
        exp_d = '0;
        @(posedge clk);
        if (acc) exp_d = mq.pop_front();
        if (w && sz < D) mq.push_back(d);
        if (w && sz == D) m_ovf = 1'b1;
        if (!m_open && sz == D) m_open = 1'b1;
        else if (m_open && sz == 0) m_open = 1'b0;
        #1;
        chk(rd_valid == acc, acc ? "R5" : "R6", W'(rd_valid), W'(acc));
        if (acc && rd_valid) begin
            chk(rd_data == exp_d, data_tag, rd_data, exp_d);
            valid_seen++;
        end
        chk(overflow == m_ovf, "R8", W'(overflow), W'(m_ovf));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        logic [W-1:0] rv;
        seed = 32'd1234;
        rv = W'($urandom(seed));
        rst = 1'b1; we = 1'b0; wd = '0; rn = 1'b1; ad = '0;
        m_open = 1'b0; m_ovf = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(wait_req == 1'b1, "R1", W'(wait_req), 1);
        chk(rd_valid == 1'b0, "R1", W'(rd_valid), 0);
        chk(overflow == 1'b0, "R1", W'(overflow), 0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(wait_req == 1'b1, "R1", W'(wait_req), 1);

        // R2: reads while filling are held off
        for (int i = 0; i < D; i++) step(1'b1, W'(16'h100 + i), 1'b0, $urandom);
        // R8: write while full is dropped
        step(1'b1, 16'hDEAD, 1'b1, '0);
        step(1'b0, '0, 1'b1, '0);

        // R9: back-to-back drain with no writes, address varied (R7)
        valid_seen = 0;
        for (int i = 0; i < D + 3; i++) step(1'b0, '0, 1'b0, $urandom);
        chk(valid_seen == D, "R9", W'(valid_seen), W'(D));

        // R3: partial refill keeps gate closed
        for (int i = 0; i < D - 1; i++) step(1'b1, W'($urandom), 1'b0, '0);
        step(1'b0, '0, 1'b0, '0);
        step(1'b1, W'($urandom), 1'b1, '0);   // now full
        step(1'b0, '0, 1'b1, '0);             // gate opens here

        // R10: simultaneous write and read while partly filled
        data_tag = "R10";
        step(1'b0, '0, 1'b0, '0);
        for (int i = 0; i < 6; i++) step(1'b1, W'($urandom), 1'b0, $urandom);
        data_tag = "R7";

        // constrained random mix
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, W'($urandom), ($urandom % 3) == 0, $urandom);

        // reset clears flag and FIFO (R1)
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        mq.delete(); m_open = 1'b0; m_ovf = 1'b0;
        @(negedge clk); rst = 1'b0;
        #1;
        chk(overflow == 1'b0, "R1", W'(overflow), 0);
        chk(wait_req == 1'b1, "R1", W'(wait_req), 1);
        step(1'b0, '0, 1'b0, '0);
        chk(rd_valid == 1'b0, "R1", W'(rd_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule